// File: doc/BRIEF.md
# Quarter-Wave Folded Twiddle Generator

This block supplies the complex rotation factors that an FFT butterfly stage multiplies against. A table index enters on every clock cycle. Three cycles later the block presents the real part (cosine) and the imaginary part (negative sine) of the rotation for that index. Both parts are signed fixed-point words whose full-scale magnitude is 2^(WIDTH-1). The indices cover angles from zero up to, but not including, pi, in steps of pi/NUM_TW.

Only one quadrant of negative-sine values is stored, in a read-only table with two registered read ports. For the first half of the indices, the imaginary port reads the low index bits and the real port reads their negation modulo the table depth. For the second half the two ports swap roles. A sign flip on the real path and two saturated constants (plus one and minus one) at the quadrant boundaries rebuild both outputs over the full half circle. The table words are computed at elaboration from the parameters. An optional clock enable stalls the whole pipeline.

Top module: `twiddleQuarterGen`

## Requirements
- R1: The result for the index presented at a clock edge with the enable active appears on twRe/twIm after exactly three enabled edges (address register, memory read register, output register).
- R2: For index k the outputs equal the quantisation of cos(pi*k/NUM_TW) and -sin(pi*k/NUM_TW): the value times 2^(WIDTH-1), truncated toward zero, then limited to the range [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R3: Index 0 yields twRe = 2^(WIDTH-1)-1 (131071 at WIDTH 18) and twIm = 0.
- R4: Index NUM_TW/2 yields twRe = 0 and twIm = -2^(WIDTH-1), the word with only the sign bit set (-131072 at WIDTH 18).
- R5: The second half of the indices is rebuilt from the same quarter table through a mirrored address, so twIm is never positive and each index of either half returns its own factor.
- R6: With USE_CE = 1, a cycle in which ce is 0 changes no pipeline register: the outputs hold, and the index input of that cycle is dropped.
- R7: With USE_CE = 0 the ce input has no effect, and the pipeline advances on every edge.
- R8: While rstN is 0, twRe and twIm read 0.
- R9: The geometry follows the parameters: the index has log2(NUM_TW) bits, NUM_TW must be a power of two of at least 8, and FFT_LEN must equal 2*NUM_TW*stride with a whole-number stride.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Pipeline advance enable (used only when USE_CE = 1) |
| index | input | log2(NUM_TW) | Twiddle table index; MSB selects the quadrant |
| twRe | output | WIDTH | Real part, signed fixed point |
| twIm | output | WIDTH | Imaginary part, signed fixed point |

## Verification
The bench targets the two quadrant boundaries. If the zero patch is missing, index 0 would return a real part of 0 instead of near plus one. If the minus-one patch is missing, index NUM_TW/2 would return an imaginary part of 0. A wrong mirror on the second quadrant would swap or misplace cosine and sine values for indices above the midpoint, and a full sweep with scrambled orderings exposes this. Stall windows with a changing index catch any stage that ignores the enable: such a stage either drifts or lets a dropped index leak into the result stream. A second instance, with a different width and depth and its enable tied off, catches any geometry or address width that was fixed to the default parameters.

// File: rtl/twiddlePkg.sv
`timescale 1ns/1ps
package twiddlePkg;

  // Strobes passed from the control path to the datapath
  typedef struct packed {
    logic advance;    // pipeline moves on this edge
    logic zeroHit;    // low index bits were zero (aligned to memory output)
    logic upperHalf;  // index MSB (aligned to memory output)
  } twStrobe_t;

  localparam real PI_VAL = 3.14159265358979323846;

  // Sine by power series after folding into [-pi, pi]
  function automatic real seriesSine(input real angle);
    real x;
    real term;
    real sum;
    x = angle;
    while (x > PI_VAL) x = x - 2.0 * PI_VAL;
    while (x < -PI_VAL) x = x + 2.0 * PI_VAL;
    term = x;
    sum  = x;
    for (int n = 1; n < 24; n++) begin
      term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // Quantised negative sine of table entry idx, limited to the signed range
  function automatic longint quantNegSin(input int idx, input int fftLen,
                                         input int stride, input int width);
    real scale;
    real theta;
    real scaled;
    longint q;
    longint lim;
    scale = 1.0;
    for (int i = 0; i < width - 1; i++) scale = scale * 2.0;
    theta  = 2.0 * PI_VAL * real'(idx) * real'(stride) / real'(fftLen);
    scaled = -seriesSine(theta) * scale;
    q      = longint'($rtoi(scaled));
    lim    = longint'(1) <<< (width - 1);
    if (q >= lim) q = lim - 1;
    if (q < -lim) q = -lim;
    return q;
  endfunction

endpackage

// File: rtl/twiddleRom.sv
`timescale 1ns/1ps
module twiddleRom #(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 8,
  parameter int FFT_LEN = 32,
  parameter int STRIDE  = 1,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     readEn,
  input  logic [ADDR_W-1:0]        addrA,
  input  logic [ADDR_W-1:0]        addrB,
  output logic signed [WIDTH-1:0]  dataA,
  output logic signed [WIDTH-1:0]  dataB
);

  logic signed [WIDTH-1:0] romWords [DEPTH];

  // Quarter-wave table of negative sine, filled at elaboration
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    localparam longint RAW = twiddlePkg::quantNegSin(g, FFT_LEN, STRIDE, WIDTH);
    assign romWords[g] = WIDTH'(RAW);
  end

  // Two registered read ports sharing the same contents
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataA <= '0;
      dataB <= '0;
    end else if (readEn) begin
      dataA <= romWords[addrA];
      dataB <= romWords[addrB];
    end
  end

endmodule

// File: rtl/twiddleCtrl.sv
`timescale 1ns/1ps
module twiddleCtrl #(
  parameter int IDX_W = 4,
  localparam int LOW_W = IDX_W - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ceEff,
  input  logic [IDX_W-1:0]       index,
  output logic [LOW_W-1:0]       realAddr,
  output logic [LOW_W-1:0]       imagAddr,
  output twiddlePkg::twStrobe_t  strobe
);

  logic [LOW_W-1:0] lowBits;
  logic [LOW_W-1:0] mirrorBits;
  logic             quadSel;
  logic             zeroS1, zeroS2;
  logic             upperS1, upperS2;

  assign lowBits    = index[LOW_W-1:0];
  assign quadSel    = index[IDX_W-1];
  assign mirrorBits = '0 - lowBits;

  // Stage 1: address register with quadrant swap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      realAddr <= '0;
      imagAddr <= '0;
      zeroS1   <= 1'b0;
      upperS1  <= 1'b0;
    end else if (ceEff) begin
      realAddr <= quadSel ? lowBits : mirrorBits;
      imagAddr <= quadSel ? mirrorBits : lowBits;
      zeroS1   <= (lowBits == '0);
      upperS1  <= quadSel;
    end
  end

  // Stage 2: flags follow the memory read register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroS2  <= 1'b0;
      upperS2 <= 1'b0;
    end else if (ceEff) begin
      zeroS2  <= zeroS1;
      upperS2 <= upperS1;
    end
  end

  assign strobe.advance   = ceEff;
  assign strobe.zeroHit   = zeroS2;
  assign strobe.upperHalf = upperS2;

  // The two port addresses are always mirror images of each other
  AST_MIRROR_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    LOW_W'(realAddr + imagAddr) == '0); // R5

endmodule

// File: rtl/twiddleDatapath.sv
`timescale 1ns/1ps
module twiddleDatapath #(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 8,
  parameter int FFT_LEN = 32,
  parameter int STRIDE  = 1,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        realAddr,
  input  logic [ADDR_W-1:0]        imagAddr,
  input  twiddlePkg::twStrobe_t    strobe,
  output logic signed [WIDTH-1:0]  twRe,
  output logic signed [WIDTH-1:0]  twIm
);

  localparam logic signed [WIDTH-1:0] PLUS_ONE  = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic signed [WIDTH-1:0] MINUS_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  logic signed [WIDTH-1:0] romRe;
  logic signed [WIDTH-1:0] romIm;

  twiddleRom #(
    .WIDTH  (WIDTH),
    .DEPTH  (DEPTH),
    .FFT_LEN(FFT_LEN),
    .STRIDE (STRIDE)
  ) rom_i (
    .clk   (clk),
    .rstN  (rstN),
    .readEn(strobe.advance),
    .addrA (realAddr),
    .addrB (imagAddr),
    .dataA (romRe),
    .dataB (romIm)
  );

  // Stage 3: symmetry patch and output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      twRe <= '0;
      twIm <= '0;
    end else if (strobe.advance) begin
      twIm <= (strobe.zeroHit && strobe.upperHalf) ? MINUS_ONE : romIm;
      if (strobe.zeroHit && !strobe.upperHalf)
        twRe <= PLUS_ONE;
      else if (strobe.upperHalf)
        twRe <= romRe;
      else
        twRe <= -romRe;
    end
  end

  // A word that gets negated must never be the most negative code
  AST_NO_NEG_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.upperHalf) |-> (romRe != MINUS_ONE)); // R2

endmodule

// File: rtl/twiddleQuarterGen.sv
`timescale 1ns/1ps
module twiddleQuarterGen #(
  parameter int WIDTH   = 18,
  parameter int FFT_LEN = 32,
  parameter int NUM_TW  = 16,
  parameter bit USE_CE  = 1'b1,
  localparam int IDX_W  = $clog2(NUM_TW),
  localparam int HALF   = NUM_TW / 2,
  localparam int STRIDE = FFT_LEN / (2 * NUM_TW)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ce,
  input  logic [IDX_W-1:0]         index,
  output logic signed [WIDTH-1:0]  twRe,
  output logic signed [WIDTH-1:0]  twIm
);

  localparam logic signed [WIDTH-1:0] PLUS_ONE  = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic signed [WIDTH-1:0] MINUS_ONE = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [IDX_W-1:0]        MID_IDX   = {1'b1, {(IDX_W-1){1'b0}}};

  // Geometry check at elaboration (R9)
  if (NUM_TW < 8 || (1 << IDX_W) != NUM_TW || STRIDE < 1 ||
      STRIDE * 2 * NUM_TW != FFT_LEN) begin : gBadGeometry
    $error("twiddleQuarterGen: unsupported FFT_LEN/NUM_TW combination");
  end

  logic ceEff;
  if (USE_CE) begin : gWithCe
    assign ceEff = ce;
  end else begin : gNoCe
    assign ceEff = 1'b1;
  end

  logic [IDX_W-2:0]       realAddr;
  logic [IDX_W-2:0]       imagAddr;
  twiddlePkg::twStrobe_t  strobe;

  twiddleCtrl #(
    .IDX_W(IDX_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .ceEff   (ceEff),
    .index   (index),
    .realAddr(realAddr),
    .imagAddr(imagAddr),
    .strobe  (strobe)
  );

  twiddleDatapath #(
    .WIDTH  (WIDTH),
    .DEPTH  (HALF),
    .FFT_LEN(FFT_LEN),
    .STRIDE (STRIDE)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .realAddr(realAddr),
    .imagAddr(imagAddr),
    .strobe  (strobe),
    .twRe    (twRe),
    .twIm    (twIm)
  );

  // Edges since reset, saturating, so three-deep history is only used once valid
  logic [1:0] warmCnt;
  always_ff @(posedge clk) begin
    if (!rstN) warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |=> (twRe == '0 && twIm == '0)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ceEff |=> ($stable(twRe) && $stable(twIm))); // R6

  AST_IM_NOT_POSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    !twIm[WIDTH-1] |-> (twIm == '0)); // R5

  AST_ZERO_IDX_UNIT: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd3 && $past(ceEff) && $past(ceEff, 2) && $past(ceEff, 3) &&
     $past(index, 3) == '0) |-> (twRe == PLUS_ONE && twIm == '0)); // R3

  AST_MID_IDX_MINUS_J: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd3 && $past(ceEff) && $past(ceEff, 2) && $past(ceEff, 3) &&
     $past(index, 3) == MID_IDX) |-> (twRe == '0 && twIm == MINUS_ONE)); // R4

endmodule

// File: tb/twiddleQuarterGen_tb.sv
`timescale 1ns/1ps
module twiddleQuarterGen_tb_top;

  localparam real CLK_PERIOD = 20.0;
  localparam real PI_REF = 3.14159265358979323846;

  // Main instance geometry
  localparam int MW = 18;
  localparam int MT = 16;
  // Alternate instance geometry
  localparam int AW = 16;
  localparam int AT = 32;

  // Stimulus vectors: scrambled orderings and repeats, walked by one loop
  localparam int NVEC = 24;
  localparam int PATTERN [NVEC] = '{0, 8, 15, 1, 7, 9, 0, 0, 8, 8, 4, 12,
                                   3, 13, 5, 11, 2, 14, 6, 10, 15, 0, 8, 7};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ce = 1'b0;
  logic [3:0] idx = '0;
  logic [4:0] idxAlt = '0;
  logic signed [MW-1:0] twRe, twIm;
  logic signed [AW-1:0] reAlt, imAlt;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int accIdx [1024];
  int nAcc = 0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  twiddleQuarterGen #(.WIDTH(MW), .FFT_LEN(32), .NUM_TW(MT), .USE_CE(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .ce(ce), .index(idx), .twRe(twRe), .twIm(twIm));

  twiddleQuarterGen #(.WIDTH(AW), .FFT_LEN(128), .NUM_TW(AT), .USE_CE(1'b0)) dutAlt_i (
    .clk(clk), .rstN(rstN), .ce(1'b0), .index(idxAlt), .twRe(reAlt), .twIm(imAlt));

  // Reference quantisation, straight from the requirement text
  function automatic int refVal(input bit isIm, input int k, input int t, input int w);
    real scale;
    real x;
    int q;
    int lim;
    scale = 1.0;
    for (int i = 0; i < w - 1; i++) scale = scale * 2.0;
    x = isIm ? -$sin(PI_REF * real'(k) / real'(t)) : $cos(PI_REF * real'(k) / real'(t));
    q = $rtoi(x * scale);
    lim = 1 << (w - 1);
    if (q >= lim) q = lim - 1;
    if (q < -lim) q = -lim;
    return q;
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // One cycle: compare against the model, then drive new inputs
  task automatic drive(input int k, input bit c, input string tag);
    @(negedge clk);
    if (nAcc >= 3) begin
      check(tag, int'(twRe), refVal(1'b0, accIdx[nAcc-3], MT, MW));
      check(tag, int'(twIm), refVal(1'b1, accIdx[nAcc-3], MT, MW));
    end
    idx = 4'(k);
    ce = c;
    if (c) begin
      accIdx[nAcc] = k;
      nAcc++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000.0);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8", int'(twRe), 0);
    check("R8", int'(twIm), 0);
    check("R8", int'(reAlt), 0);
    rstN = 1'b1;

    // R1: vector table walked back to back
    for (int v = 0; v < NVEC; v++) drive(PATTERN[v], 1'b1, "R1");

    // R2/R5: full sweep, both halves
    for (int k = 0; k < MT; k++) begin
      drive(k, 1'b1, "R2");
      check("R5", (twIm > 0) ? 1 : 0, 0);
    end

    // R6: stalls with a changing index, then resume
    drive(5, 1'b1, "R6");
    drive(10, 1'b1, "R6");
    for (int s = 0; s < 4; s++) drive(3 + s, 1'b0, "R6");
    drive(14, 1'b1, "R6");
    drive(1, 1'b0, "R6");
    drive(2, 1'b1, "R6");
    for (int s = 0; s < 3; s++) drive(9, 1'b1, "R6");

    // R3: index 0 against hand constants
    repeat (3) drive(0, 1'b1, "R3");
    drive(0, 1'b0, "R3");
    check("R3", int'(twRe), 131071);
    check("R3", int'(twIm), 0);

    // R4: index at the midpoint
    repeat (3) drive(8, 1'b1, "R4");
    drive(8, 1'b0, "R4");
    check("R4", int'(twRe), 0);
    check("R4", int'(twIm), -131072);

    // R7/R9: alternate geometry, enable tied low but ignored
    for (int s = 0; s < AT + 3; s++) begin
      @(negedge clk);
      if (s >= 3) begin
        check("R7", int'(reAlt), refVal(1'b0, s - 3, AT, AW));
        check("R9", int'(imAlt), refVal(1'b1, s - 3, AT, AW));
      end
      if (s < AT) idxAlt = 5'(s);
    end

    // R8: reset in the middle of traffic
    drive(3, 1'b1, "R8");
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R8", int'(twRe), 0);
    check("R8", int'(twIm), 0);
    check("R8", int'(reAlt), 0);
    check("R8", int'(imAlt), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule